// File: doc/BRIEF.md
# Seconds Tick Prescaler with External Test Clock

This block produces the one-second tick of a real-time clock. In normal running, a prescaler counts strobes from the divided crystal path (`osc_stb_i`, one system-clock cycle wide). With the test-source bit set, the same prescaler counts rising edges of an asynchronous pin (`ext_clk_i`) instead. The pin passes through a two-flop synchroniser and an edge detector that both run on the system clock. A board tester can therefore step the time registers by hand, without waiting on a crystal.

A freeze bit holds the prescaler at the midpoint of its range and holds the time registers still. When the freeze bit is released, the first tick comes after half a prescaler period (32 source events with the default 6-bit prescaler). Every later tick comes after a full period (64 events). A small seconds/minutes counter advances on each tick, so the increments can be watched at the outputs. A write port loads that counter, usually while the block is frozen, before pulses are applied.

Top module: `rtc_tick_gen`

## Requirements
- R1: While `rst_n` is low and right after reset, `sec_o` = 0, `min_o` = 0 and `tick_o` = 0, and the prescaler sits at its midpoint (32).
- R2: With `test_sel_i` = 1, the event source is each rising edge of `ext_clk_i`, counted two synchroniser stages plus one edge-detect compare after it is sampled. Here `osc_stb_i` is ignored. With `test_sel_i` = 0, the source is `osc_stb_i` and edges on `ext_clk_i` have no effect.
- R3: While `stop_i` = 1, the prescaler is held at 32, no tick is produced, and `sec_o`/`min_o` keep their value unless written.
- R4: After `stop_i` falls, the first tick happens on the 32nd source event.
- R5: After a tick, the next tick happens on the 64th further source event.
- R6: `tick_o` is high for exactly one cycle per tick. In that same cycle `sec_o` first shows the advanced value.
- R7: On a tick, `sec_o` counts up by one. From 59 it wraps to 0 and `min_o` counts up by one.
- R8: On a tick with `sec_o` = 59 and `min_o` = 59, both wrap to 0.
- R9: With `wr_en_i` = 1, `sec_o`/`min_o` take `wr_sec_i`/`wr_min_i` on the next edge, with any value above 59 stored as 59. The write wins over a tick in the same cycle: no tick, and no advance. The prescaler is not affected by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_sel_i | input | 1 | 1: count external pin edges; 0: count oscillator strobes |
| stop_i | input | 1 | Freeze prescaler and time registers |
| osc_stb_i | input | 1 | One-cycle strobe from the divided crystal path |
| ext_clk_i | input | 1 | Asynchronous external test pulse pin |
| wr_en_i | input | 1 | Load the time registers |
| wr_sec_i | input | 6 | Seconds value to load |
| wr_min_i | input | 6 | Minutes value to load |
| tick_o | output | 1 | One-cycle seconds tick |
| sec_o | output | 6 | Seconds count, 0..59 |
| min_o | output | 6 | Minutes count, 0..59 |

## Verification
The bench steps the pin 31 and then 32 times after release, and 63 and then 64 times after a tick. A prescaler released from zero, or one that drifts by one, would move the seconds at the wrong pulse. Pin edges are applied in oscillator mode and pulses are applied while frozen; a source mux or a freeze that leaks would advance the time. Loads of 59:59, 12:59 and an out-of-range 63 check the carry, the double wrap and the clamp. Oscillator strobes arrive every cycle while writes land near a wrap, and a per-cycle model comparison catches a write that lets the tick through or shifts the prescaler.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
    localparam int PRE_W     = 6;
    localparam int TIME_W    = 6;
    localparam int TIME_LAST = 59;
    localparam int SYNC_N    = 2;

    typedef struct packed {
        logic [TIME_W-1:0] sec;
        logic [TIME_W-1:0] min;
        logic              tick;
    } time_st_t;
endpackage

// File: rtl/rtcp_edge_sync.sv
module rtcp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // chain[0..STAGES-1] synchroniser, chain[STAGES] previous value for edge detect
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i <= STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];

    // R2: a detected rise is a one-cycle event
    assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/rtcp_prescaler.sv
module rtcp_prescaler #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_i,
    input  logic         stop_i,
    output logic         wrap_o,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MID  = W'(1) << (W-1);
    localparam logic [W-1:0] LAST = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    at_last;

    assign at_last = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (stop_i) begin
            st_d.cnt = MID;
        end else if (evt_i) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: MID};
        else        st_q <= st_d;
    end

    assign wrap_o = evt_i & ~stop_i & at_last;
    assign cnt_o  = st_q.cnt;

    assert_hold_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (cnt_o == MID));

    // R5: after a wrap the count restarts from zero
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_i && !evt_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rtcp_time_cnt.sv
module rtcp_time_cnt
    import rtcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              wr_en_i,
    input  logic [TIME_W-1:0] wr_sec_i,
    input  logic [TIME_W-1:0] wr_min_i,
    output logic [TIME_W-1:0] sec_o,
    output logic [TIME_W-1:0] min_o,
    output logic              tick_o
);
    localparam logic [TIME_W-1:0] LAST = TIME_W'(TIME_LAST);

    time_st_t st_d, st_q;

    function automatic logic [TIME_W-1:0] clamp(input logic [TIME_W-1:0] v);
        return (v > LAST) ? LAST : v;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (wr_en_i) begin
            st_d.sec = clamp(wr_sec_i);
            st_d.min = clamp(wr_min_i);
        end else if (adv_i) begin
            st_d.tick = 1'b1;
            if (st_q.sec == LAST) begin
                st_d.sec = '0;
                st_d.min = (st_q.min == LAST) ? '0 : st_q.min + TIME_W'(1);
            end else begin
                st_d.sec = st_q.sec + TIME_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec_o  = st_q.sec;
    assign min_o  = st_q.min;
    assign tick_o = st_q.tick;

    assert_sec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o <= LAST);

    assert_min_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        min_o <= LAST);

    assert_write_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> !tick_o);

    assert_tick_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> !$stable(sec_o));
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
    import rtcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_sel_i,
    input  logic              stop_i,
    input  logic              osc_stb_i,
    input  logic              ext_clk_i,
    input  logic              wr_en_i,
    input  logic [TIME_W-1:0] wr_sec_i,
    input  logic [TIME_W-1:0] wr_min_i,
    output logic              tick_o,
    output logic [TIME_W-1:0] sec_o,
    output logic [TIME_W-1:0] min_o
);
    logic             ext_rise;
    logic             src_evt;
    logic             wrap;
    logic [PRE_W-1:0] pre_cnt;

    rtcp_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_clk_i),
        .rise_o  (ext_rise)
    );

    assign src_evt = test_sel_i ? ext_rise : osc_stb_i;

    rtcp_prescaler #(.W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (src_evt),
        .stop_i (stop_i),
        .wrap_o (wrap),
        .cnt_o  (pre_cnt)
    );

    rtcp_time_cnt u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (wrap),
        .wr_en_i  (wr_en_i),
        .wr_sec_i (wr_sec_i),
        .wr_min_i (wr_min_i),
        .sec_o    (sec_o),
        .min_o    (min_o),
        .tick_o   (tick_o)
    );

    assert_stop_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !tick_o);

    assert_stop_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o)));

    assert_tick_from_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> ($past(pre_cnt) == {PRE_W{1'b1}}));
endmodule

// File: tb/test_rtc_tick_gen.sv
module test_rtc_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_sel = 1'b0, stop = 1'b0, osc = 1'b0, ext = 1'b0, wr = 1'b0;
    logic [5:0] wsec = '0, wmin = '0;
    logic       tick;
    logic [5:0] sec, min;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    int m_pre = 32, m_sec = 0, m_min = 0, m_tick = 0;
    int e1 = 0, e2 = 0, e3 = 0;
    int tick_seen = 0;

    always #4 clk = ~clk;

    rtc_tick_gen i_rtc_tick_gen (
        .clk(clk), .rst_n(rst_n), .test_sel_i(test_sel), .stop_i(stop),
        .osc_stb_i(osc), .ext_clk_i(ext), .wr_en_i(wr),
        .wr_sec_i(wsec), .wr_min_i(wmin),
        .tick_o(tick), .sec_o(sec), .min_o(min)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 32; m_sec = 0; m_min = 0; m_tick = 0; e1 = 0; e2 = 0; e3 = 0;
        end else begin
            int evt, wrap;
            evt  = test_sel ? (e2 == 1 && e3 == 0) : int'(osc);
            wrap = 0;
            if (stop) m_pre = 32;
            else if (evt != 0) begin
                if (m_pre == 63) begin m_pre = 0; wrap = 1; end
                else m_pre++;
            end
            e3 = e2; e2 = e1; e1 = int'(ext);
            m_tick = 0;
            if (wr) begin
                m_sec = (wsec > 59) ? 59 : int'(wsec);
                m_min = (wmin > 59) ? 59 : int'(wmin);
            end else if (wrap != 0) begin
                m_tick = 1;
                m_sec++;
                if (m_sec == 60) begin
                    m_sec = 0; m_min++;
                    if (m_min == 60) m_min = 0;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge (R6 timing, R2 latency)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(tick) == m_tick, "R6 tick vs model", int'(tick), m_tick);
            chk(int'(sec) == m_sec, "R7 sec vs model", int'(sec), m_sec);
            chk(int'(min) == m_min, "R8 min vs model", int'(min), m_min);
            if (tick) tick_seen++;
        end
    end

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ext = 1'b1;
            repeat (2) @(negedge clk);
            ext = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic load(input int s, input int m);
        @(negedge clk) begin wr = 1'b1; wsec = 6'(s); wmin = 6'(m); end
        @(negedge clk) wr = 1'b0;
    endtask

    task automatic release_stop();
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        chk(tick == 1'b0 && sec == 0 && min == 0, "R1 reset state", int'(sec), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sec == 0 && min == 0, "R1 after reset", int'(min), 0);

        // R2: pin edges ignored in oscillator mode
        pulses(100);
        chk(sec == 0, "R2 ext ignored when test_sel=0", int'(sec), 0);

        // test mode, frozen: R3
        test_sel = 1'b1;
        @(negedge clk) stop = 1'b1;
        pulses(100);
        chk(sec == 0 && min == 0, "R3 frozen under pulses", int'(sec), 0);
        load(10, 5);
        chk(sec == 10 && min == 5, "R9 load while stopped", int'(sec), 10);
        load(63, 63);
        chk(sec == 59 && min == 59, "R9 clamp to 59", int'(sec), 59);
        load(10, 5);
        @(negedge clk) stop = 1'b0;

        // R4: first step at 32 events
        t0 = tick_seen;
        pulses(31);
        chk(sec == 10, "R4 no step after 31", int'(sec), 10);
        pulses(1);
        chk(sec == 11, "R4 step at 32", int'(sec), 11);
        chk(tick_seen - t0 == 1, "R6 one tick cycle", tick_seen - t0, 1);
        // R5: next at 64
        pulses(63);
        chk(sec == 11, "R5 no step after 63", int'(sec), 11);
        pulses(1);
        chk(sec == 12, "R5 step at 64", int'(sec), 12);

        // R7 carry
        @(negedge clk) stop = 1'b1;
        load(59, 12);
        @(negedge clk) stop = 1'b0;
        pulses(32);
        chk(sec == 0 && min == 13, "R7 carry to minutes", int'(min), 13);
        // R8 double wrap
        @(negedge clk) stop = 1'b1;
        load(59, 59);
        @(negedge clk) stop = 1'b0;
        pulses(32);
        chk(sec == 0 && min == 0, "R8 wrap 59:59", int'(min), 0);

        // oscillator mode: R2 source switch, pin ignored
        test_sel = 1'b0;
        release_stop();
        load(0, 0);
        for (int i = 0; i < 31; i++) begin
            @(negedge clk) osc = 1'b1;
            @(negedge clk) osc = 1'b0;
        end
        chk(sec == 0, "R2 osc no step after 31", int'(sec), 0);
        @(negedge clk) osc = 1'b1;
        @(negedge clk) osc = 1'b0;
        repeat (2) @(negedge clk);
        chk(sec == 1, "R2 osc step at 32", int'(sec), 1);

        // R9: writes racing wraps, strobe every cycle
        @(negedge clk) osc = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk) begin
                wr = (i % 61 == 0) || (i % 64 == 63);
                wsec = 6'(i % 64); wmin = 6'((i / 7) % 64);
            end
        end
        @(negedge clk) begin wr = 1'b0; osc = 1'b0; end
        repeat (4) @(negedge clk);
        chk(sec <= 59, "R9 race stays in range", int'(sec), 59);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule